// File: doc/BRIEF.md
# Keyed-configuration GPIO port

This block is an eight-pin general-purpose I/O unit with its own register access logic. Software reaches its registers through a pair of I/O ports, an index port and the data port one address above it. The pair stays locked until the index port receives the key byte 26h in two consecutive writes. Once the pair is unlocked, software writes a register number to the index port and then reads or writes that register through the data port. Writing AAh to the index port locks the pair again.

The registers set each pin's direction, its output value, and an inversion mask that acts on both the incoming and the outgoing path. Further registers hold a global enable, an alternate-function select and a 16-bit direct-access address. Once that address is programmed, a plain I/O read or write to it gives access to all eight pin states without unlocking the configuration pair. A pin handed to its alternate function, whether by strap or by software, is never driven by this block. The pad drivers and the alternate functions themselves lie outside the block.

Top module: `gpio_cfg_port`

## Requirements
- R1: After reset the pair is locked. It unlocks only when two consecutive I/O writes to the index port both carry 26h. While the pair is locked, reads of the index or data port return FFh and writes to the data port change nothing.
- R2: While the pair is locked, any write to the index port with a byte other than 26h clears a pending first key, so a further two key writes are then needed.
- R3: While the pair is unlocked, writing AAh to the index port locks it again, and that write does not change the selected register number. Any other byte written to the index port becomes the selected register number.
- R4: The index/data pair sits at 004Eh/004Fh. It moves to 002Eh/002Fh when the input `strap_alt_base` is 1 or when bit 4 of register 03h is 1. Either change takes effect on the next access.
- R5: The register numbers are as follows. 03h is control, with bit 4 relocating the pair. 04h is the alternate-function select. 10h is the GPIO enable, bit 0. 11h and 12h are the low and high bytes of the direct-access address. 14h is direction, 15h is data and 16h is inversion. Any other number reads back 00h.
- R6: Direction resets to FFh, and a 1 bit makes that pin an input. `pin_oe[n]` is 1 only when the enable is 1, pin n is an output and pin n is not assigned to its alternate function.
- R7: A write to the data register changes only the bits of output pins. A read returns the stored bit for output pins and the inverted-as-configured pin level for input pins.
- R8: `pin_out` equals the data register XOR the inversion register. An input pin reads as `pin_in` XOR the inversion register.
- R9: Registers 11h, 12h, 14h, 15h and 16h take writes only while the enable bit is 1. A write that sets the enable bit from 0 to 1 restores direction to FFh and data, inversion and the direct address to 00h.
- R10: While the enable bit is 1, an I/O write to the direct-access address updates the data register with the R7 rule, and an I/O read returns the R7 read value. Neither access needs the pair to be unlocked. The configuration pair takes priority if the addresses coincide, and unmatched addresses read 00h.
- R11: The effective alternate-function select is `strap_fsel` OR register 04h, and it reads back through register 04h. Strap-assigned pins stay assigned whatever the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read strobe; read data is valid in the same cycle |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| strap_alt_base | input | 1 | 1 selects the 002Eh/002Fh pair |
| strap_fsel | input | 8 | Pins assigned to their alternate function by strap |
| pin_in | input | 8 | Pin input levels |
| io_rdata | output | 8 | I/O read data, 00h when `io_rd` is 0 |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |

## Verification
A wrong key-counter or lock state shows up on the very next data-port read, as FFh where a register value was expected or the reverse. A corrupted direction, data or inversion register shows up on `pin_out` and `pin_oe` in the cycle after the write that set it, and on the following read of the data register or the direct port. Sweeping all 256 direction values, each paired with varied data, inversion and pin levels, exposes a bit-level slip in the merge or the inversion within one register write.

// File: rtl/gpio_cfg_port.sv
module gpio_cfg_port #(
  parameter logic [7:0]  KEY      = 8'h26,
  parameter logic [7:0]  EXIT_KEY = 8'hAA,
  parameter logic [15:0] BASE_DEF = 16'h004E,
  parameter logic [15:0] BASE_ALT = 16'h002E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_wdata,
  input  logic        strap_alt_base,
  input  logic [7:0]  strap_fsel,
  input  logic [7:0]  pin_in,
  output logic [7:0]  io_rdata,
  output logic [7:0]  pin_out,
  output logic [7:0]  pin_oe
);
  localparam logic [7:0] IX_CTRL = 8'h03, IX_FSEL = 8'h04, IX_EN  = 8'h10;
  localparam logic [7:0] IX_PLO  = 8'h11, IX_PHI  = 8'h12, IX_DIR = 8'h14;
  localparam logic [7:0] IX_DAT  = 8'h15, IX_INV  = 8'h16;

  logic        cfg_open, key_half, en_q;
  logic [7:0]  idx_q, ctrl_q, fsel_q, dir_q, dat_q, inv_q;
  logic [15:0] padr_q;
  logic [7:0]  reg_rd;

  wire [15:0] idx_port = (strap_alt_base | ctrl_q[4]) ? BASE_ALT : BASE_DEF;
  wire [15:0] dat_port = idx_port + 16'd1;
  wire        at_idx   = io_addr == idx_port;
  wire        at_dat   = io_addr == dat_port;
  wire        wr_idx   = io_wr && at_idx;
  wire        wr_dat   = io_wr && at_dat && cfg_open;
  wire        port_hit = en_q && io_addr == padr_q && !at_idx && !at_dat;
  wire [7:0]  fsel_eff = strap_fsel | fsel_q;
  wire [7:0]  pin_view = (dat_q & ~dir_q) | ((pin_in ^ inv_q) & dir_q);
  wire [7:0]  dat_next = (io_wdata & ~dir_q) | (dat_q & dir_q);
  wire        en_rise  = wr_dat && idx_q == IX_EN && io_wdata[0] && !en_q;

  assign pin_out = dat_q ^ inv_q;
  assign pin_oe  = en_q ? (~dir_q & ~fsel_eff) : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_open <= 1'b0;
      key_half <= 1'b0;
      en_q     <= 1'b0;
      idx_q    <= 8'h00;
      ctrl_q   <= 8'h00;
      fsel_q   <= 8'h00;
      dir_q    <= 8'hFF;
      dat_q    <= 8'h00;
      inv_q    <= 8'h00;
      padr_q   <= 16'h0000;
    end else begin
      if (wr_idx) begin
        if (!cfg_open) begin
          if (io_wdata == KEY) begin
            cfg_open <= key_half;
            key_half <= !key_half;
          end else begin
            key_half <= 1'b0;
          end
        end else if (io_wdata == EXIT_KEY) begin
          cfg_open <= 1'b0;
        end else begin
          idx_q <= io_wdata;
        end
      end
      if (wr_dat) begin
        case (idx_q)
          IX_CTRL: ctrl_q <= io_wdata;
          IX_FSEL: fsel_q <= io_wdata;
          IX_EN:   en_q   <= io_wdata[0];
          IX_PLO:  if (en_q) padr_q[7:0]  <= io_wdata;
          IX_PHI:  if (en_q) padr_q[15:8] <= io_wdata;
          IX_DIR:  if (en_q) dir_q <= io_wdata;
          IX_DAT:  if (en_q) dat_q <= dat_next;
          IX_INV:  if (en_q) inv_q <= io_wdata;
          default: ;
        endcase
      end
      if (io_wr && port_hit) dat_q <= dat_next;
      if (en_rise) begin
        dir_q  <= 8'hFF;
        dat_q  <= 8'h00;
        inv_q  <= 8'h00;
        padr_q <= 16'h0000;
      end
    end
  end

  always_comb begin
    case (idx_q)
      IX_CTRL: reg_rd = ctrl_q;
      IX_FSEL: reg_rd = fsel_eff;
      IX_EN:   reg_rd = {7'b0, en_q};
      IX_PLO:  reg_rd = padr_q[7:0];
      IX_PHI:  reg_rd = padr_q[15:8];
      IX_DIR:  reg_rd = dir_q;
      IX_DAT:  reg_rd = pin_view;
      IX_INV:  reg_rd = inv_q;
      default: reg_rd = 8'h00;
    endcase
  end

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd) begin
      if (at_idx)        io_rdata = cfg_open ? idx_q : 8'hFF;
      else if (at_dat)   io_rdata = cfg_open ? reg_rd : 8'hFF;
      else if (port_hit) io_rdata = pin_view;
    end
  end

  assert_unlock_by_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && at_idx && io_wdata == KEY && key_half));
  assert_locked_reads_ff_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !cfg_open && at_dat) |-> io_rdata == 8'hFF);
  assert_defaults_on_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (dir_q == 8'hFF && dat_q == 8'h00 && inv_q == 8'h00 && padr_q == 16'h0));
  assert_frozen_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (en_q || $stable(dir_q)));
  assert_strap_pin_undriven_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & strap_fsel) == 8'h00);
  assert_exit_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && wr_idx && io_wdata == EXIT_KEY) |=> !cfg_open);
endmodule

// File: tb/gpio_cfg_port_tb.sv
module gpio_cfg_port_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic [7:0]  io_wdata = 8'h0;
  logic        strap_alt_base = 1'b0;
  logic [7:0]  strap_fsel = 8'h0, pin_in = 8'h0;
  logic [7:0]  io_rdata, pin_out, pin_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .strap_alt_base(strap_alt_base), .strap_fsel(strap_fsel),
    .pin_in(pin_in), .io_rdata(io_rdata), .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  logic [15:0] ix = 16'h004E;
  task automatic creg(input logic [7:0] r, input logic [7:0] v);
    wr(ix, r); wr(ix + 16'd1, v);
  endtask
  task automatic rreg(input logic [7:0] r, output logic [7:0] v);
    wr(ix, r); rd(ix + 16'd1, v);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 00 expected 01");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, mdat, dir, inv, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset oe", pin_oe, 8'h00);
    rd(16'h004F, v); chk("R1 locked data read", v, 8'hFF);
    rd(16'h004E, v); chk("R1 locked index read", v, 8'hFF);

    wr(ix, 8'h26); wr(ix, 8'h26);
    rreg(8'h14, v); chk("R6 dir reset", v, 8'hFF);
    creg(8'h14, 8'h00);
    rreg(8'h14, v); chk("R9 write ignored when off", v, 8'hFF);
    rreg(8'h30, v); chk("R5 unassigned index", v, 8'h00);

    wr(ix, 8'h04); wr(ix, 8'hAA);
    rd(16'h004F, v); chk("R3 exit locks", v, 8'hFF);
    wr(16'h004F, 8'h77);
    wr(ix, 8'h26); wr(ix, 8'h27); wr(ix, 8'h26);
    rd(16'h004F, v); chk("R2 broken key stays locked", v, 8'hFF);
    wr(ix, 8'h26);
    rd(ix, v); chk("R3 index kept across exit", v, 8'h04);
    rd(16'h004F, v); chk("R1 locked write ignored", v, 8'h00);

    creg(8'h10, 8'h01);
    mdat = 8'h00;
    for (int k = 0; k < 256; k++) begin
      dir = 8'(k);
      inv = 8'(k * 53);
      w   = 8'(k * 29 + 7);
      pin_in = 8'(k) ^ 8'h5A;
      creg(8'h14, dir);
      creg(8'h16, inv);
      creg(8'h15, w);
      mdat = (w & ~dir) | (mdat & dir);
      chk("R6 oe follows direction", pin_oe, ~dir);
      chk("R8 output inversion", pin_out, mdat ^ inv);
      rd(ix + 16'd1, v);
      chk("R7 data read merge", v, (mdat & ~dir) | ((pin_in ^ inv) & dir));
    end

    creg(8'h10, 8'h00);
    chk("R6 oe off when disabled", pin_oe, 8'h00);
    creg(8'h14, 8'h55);
    rreg(8'h14, v); chk("R9 dir frozen", v, 8'hFF);
    creg(8'h10, 8'h01);
    rreg(8'h14, v); chk("R9 dir default", v, 8'hFF);
    rreg(8'h15, v); chk("R9 data default", v, pin_in);
    rreg(8'h16, v); chk("R9 inv default", v, 8'h00);

    creg(8'h11, 8'h50); creg(8'h12, 8'h01);
    creg(8'h14, 8'h0F); creg(8'h16, 8'h03);
    wr(ix, 8'hAA);
    wr(16'h0150, 8'hAA);
    mdat = 8'hA0;
    chk("R10 direct write pins", pin_out, 8'hA3);
    chk("R10 direct oe", pin_oe, 8'hF0);
    for (int p = 0; p < 256; p++) begin
      pin_in = 8'(p);
      rd(16'h0150, v);
      chk("R10 direct read", v, (mdat & 8'hF0) | ((pin_in ^ 8'h03) & 8'h0F));
    end
    rd(16'h0151, v); chk("R10 unmatched read", v, 8'h00);

    wr(ix, 8'h26); wr(ix, 8'h26);
    creg(8'h04, 8'h30);
    strap_fsel = 8'h01;
    @(negedge clk);
    chk("R11 alt pins undriven", pin_oe, 8'hC0);
    rreg(8'h04, v); chk("R11 fsel readback", v, 8'h31);
    creg(8'h10, 8'h00);
    rreg(8'h04, v); chk("R11 strap kept when off", v, 8'h31);

    creg(8'h03, 8'h10);
    rd(16'h002E, v); chk("R4 ctrl moves pair", v, 8'h03);
    rd(16'h004E, v); chk("R4 old index unmapped", v, 8'h00);
    ix = 16'h002E;
    creg(8'h03, 8'h00);
    ix = 16'h004E;
    rd(16'h004E, v); chk("R4 ctrl back to default", v, 8'h03);
    wr(ix, 8'hAA);
    strap_alt_base = 1'b1;
    wr(16'h004E, 8'h26); wr(16'h004E, 8'h26);
    rd(16'h002F, v); chk("R4 strap pair locked", v, 8'hFF);
    wr(16'h002E, 8'h26); wr(16'h002E, 8'h26);
    rd(16'h002E, v); chk("R4 strap pair unlocks", v, 8'h03);
    ix = 16'h002E;
    rreg(8'h21, v); chk("R5 unassigned via strap pair", v, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule